// File: doc/BRIEF.md
# Multi-Channel DMA Control and Status Register Unit

This block is the memory-mapped front end of a descriptor-based DMA with several channels. A host issues 32-bit word accesses; the upper address bits pick a channel window of 0x2000 bytes, and address bits 7:2 pick a register inside that window. Each channel keeps its own pointer registers, a configuration word, a command word, an interrupt mask and a pending-interrupt word, and a stream-command word. The status word is not stored; it is assembled when it is read, from the channel state and from live signals supplied by the channel engine.

Each channel has a one-hot state (reset, stopped, running). Configuration writes move it to stopped or to reset, and a stream command that asks for a data-descriptor load together with a burst start moves it to running. Commands to the engine leave the block as one-cycle pulses: data-descriptor load, context-descriptor load, start and continue. The engine sends interrupt-set pulses back. Each channel drives one interrupt line, the OR of its pending bits masked by its enable mask. Accesses wider or narrower than a word are reported on an error pulse and change nothing.

Top module: `dmacsr_top`

## Requirements
- R1: Channel index is the address shifted right by 13 and register index is address bits 7:2. The mapped word offsets inside a window are: 0x00 data pointer, 0x58 saved pointer, 0x5C saved buffer pointer, 0x60 group, 0x7C group-down, 0x80 command, 0x84 config, 0x88 status, 0x8C mask, 0x90 acknowledge, 0x94 pending, 0x98 masked pending, 0x9C stream command. A read returns its data on `bus_rdata` with `bus_rvalid` high in the cycle after the request. Unmapped offsets and absent channels read zero and ignore writes.
- R2: After reset every register reads zero, except status, which reads 1 (state reset).
- R3: Config bit 0 is enable and bit 1 is stop. A config write with bit 1 set forces state stopped (2). A config write with bit 0 clear forces state reset (1), and this takes priority. Any other config write leaves the state unchanged. The state is always one-hot: 1 reset, 2 stopped, 4 running.
- R4: Status reads return the state in bits 2:0, the engine's live end-of-list flag in bit 5 and the engine's live stream source (SRC_W bits) from bit 8 upward. All other bits are zero.
- R5: A write to acknowledge clears every pending bit that is set in the written value. Acknowledge always reads zero.
- R6: Masked pending reads as pending AND mask. A channel's `irq` bit is high when any masked pending bit is set, and it follows mask, acknowledge and set changes from the cycle after they happen.
- R7: An engine interrupt-set pulse (IRQ_W bits, landing in pending bits IRQ_W-1:0) sets those pending bits. When it arrives in the same cycle as an acknowledge write, the set wins over the clear.
- R8: A stream-command write keeps only bits 9:0, and that is what reads back. If any bit of 0x140 is set, a one-cycle `ld_data` pulse follows. If bit 5 (0x20) is also set, a one-cycle `start_ch` pulse follows and the state becomes running. If bit 9 (0x200) is set, a one-cycle `ld_ctx` pulse follows.
- R9: A command write stores the value and gives a one-cycle `cont_req` pulse. If any bit above bit 0 is set, `cmd_bad` pulses in the same cycle.
- R10: A request whose `bus_size` is not 4 gives a one-cycle `bus_err` pulse in the next cycle. It returns no read data and changes no register.
- R11: Pointer registers, mask and config of each channel read back the last value written, and writes to one channel leave the other channels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_size | input | 3 | Access size in bytes; only 4 is legal |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after the request |
| bus_err | output | 1 | Illegal-size access pulse |
| eng_eol | input | NUM_CH | Engine end-of-list flag per channel |
| eng_src | input | NUM_CH*SRC_W | Engine stream source per channel |
| eng_irq_set | input | NUM_CH*IRQ_W | Interrupt-set pulses per channel |
| ld_data | output | NUM_CH | Load data descriptor pulse |
| ld_ctx | output | NUM_CH | Load context descriptor pulse |
| start_ch | output | NUM_CH | Channel start pulse |
| cont_req | output | NUM_CH | Continue request pulse |
| cmd_bad | output | NUM_CH | Invalid command store pulse |
| irq | output | NUM_CH | Interrupt line per channel |

## Verification
Every result of this block is due one clock edge after its cause. Read data, the error pulse and the engine pulses are all registered at the edge that samples the request, and the interrupt line reflects pending and mask state registered at the edge that sampled the write or the set pulse. The bench drives inputs on falling edges, advances its reference model at each rising edge from the inputs it sees there, and compares every output 2 ns after that edge, which is where each result first appears. Directed checks sample at the falling edge after a request, so a one-cycle pulse is still high when it is checked.

// File: rtl/dmacsr_pkg.sv
package dmacsr_pkg;

    typedef enum logic [2:0] {
        ST_RESET   = 3'd1,
        ST_STOPPED = 3'd2,
        ST_RUNNING = 3'd4
    } ch_state_e;

    localparam int WIN_SHIFT = 13;
    localparam int IDX_W     = 6;

    localparam logic [IDX_W-1:0] IX_DATA   = 6'h00;
    localparam logic [IDX_W-1:0] IX_SAVED  = 6'h16;
    localparam logic [IDX_W-1:0] IX_SBUF   = 6'h17;
    localparam logic [IDX_W-1:0] IX_GROUP  = 6'h18;
    localparam logic [IDX_W-1:0] IX_GDOWN  = 6'h1F;
    localparam logic [IDX_W-1:0] IX_CMD    = 6'h20;
    localparam logic [IDX_W-1:0] IX_CFG    = 6'h21;
    localparam logic [IDX_W-1:0] IX_STAT   = 6'h22;
    localparam logic [IDX_W-1:0] IX_MASK   = 6'h23;
    localparam logic [IDX_W-1:0] IX_ACK    = 6'h24;
    localparam logic [IDX_W-1:0] IX_RAW    = 6'h25;
    localparam logic [IDX_W-1:0] IX_MASKED = 6'h26;
    localparam logic [IDX_W-1:0] IX_STREAM = 6'h27;

    localparam int SC_W = 10;
    localparam logic [SC_W-1:0] SC_LOAD_D = 10'h140;
    localparam logic [SC_W-1:0] SC_LOAD_C = 10'h200;
    localparam int SC_BURST_BIT = 5;

    localparam int STAT_EOL_BIT = 5;
    localparam int STAT_SRC_LSB = 8;

    typedef struct packed {
        logic [31:0]     data;
        logic [31:0]     saved;
        logic [31:0]     sbuf;
        logic [31:0]     grp;
        logic [31:0]     gdown;
        logic [31:0]     cmd;
        logic [31:0]     cfg;
        logic [31:0]     mask;
        logic [31:0]     pend;
        logic [SC_W-1:0] stream;
        ch_state_e       state;
        logic            ld_d;
        logic            ld_c;
        logic            go;
        logic            cont;
        logic            bad;
    } chan_q_t;

    typedef struct packed {
        logic        rvalid;
        logic [31:0] rdata;
        logic        err;
    } bus_q_t;

endpackage

// File: rtl/dmacsr_decode.sv
module dmacsr_decode
    import dmacsr_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CH_W   = 1,
    parameter int ADDR_W = 14
) (
    input  logic              req,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        size,
    output logic              wr_hit,
    output logic              rd_req,
    output logic              bad_size,
    output logic              ch_ok,
    output logic [CH_W-1:0]   ch,
    output logic [IDX_W-1:0]  idx
);
    logic word_ok;
    logic unused_bits;

    assign unused_bits = ^{addr[WIN_SHIFT-1:8], addr[1:0]};

    always_comb begin
        word_ok  = (size == 3'd4);
        ch       = addr[ADDR_W-1:WIN_SHIFT];
        idx      = addr[7:2];
        ch_ok    = (32'(ch) < NUM_CH);
        bad_size = req && !word_ok;
        rd_req   = req && word_ok && !wr;
        wr_hit   = req && word_ok && wr && ch_ok;
    end

endmodule

// File: rtl/dmacsr_chan.sv
module dmacsr_chan
    import dmacsr_pkg::*;
#(
    parameter int SRC_W = 8,
    parameter int IRQ_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [31:0]       wdata,
    input  logic              eng_eol,
    input  logic [SRC_W-1:0]  eng_src,
    input  logic [IRQ_W-1:0]  irq_set,
    output logic [31:0]       rd_word,
    output logic              irq,
    output logic              ld_data,
    output logic              ld_ctx,
    output logic              start,
    output logic              cont,
    output logic              bad_cmd
);
    chan_q_t q, d;
    logic [31:0] stat_w;
    logic [31:0] masked_w;

    always_comb begin
        d      = q;
        d.ld_d = 1'b0;
        d.ld_c = 1'b0;
        d.go   = 1'b0;
        d.cont = 1'b0;
        d.bad  = 1'b0;
        if (wr_en) begin
            case (idx)
                IX_DATA:  d.data  = wdata;
                IX_SAVED: d.saved = wdata;
                IX_SBUF:  d.sbuf  = wdata;
                IX_GROUP: d.grp   = wdata;
                IX_GDOWN: d.gdown = wdata;
                IX_MASK:  d.mask  = wdata;
                IX_CMD: begin
                    d.cmd  = wdata;
                    d.cont = 1'b1;
                    d.bad  = |wdata[31:1];
                end
                IX_CFG: begin
                    d.cfg = wdata;
                    if (wdata[1])  d.state = ST_STOPPED;
                    if (!wdata[0]) d.state = ST_RESET;
                end
                IX_ACK: d.pend = q.pend & ~wdata;
                IX_STREAM: begin
                    d.stream = wdata[SC_W-1:0];
                    if (|(wdata[SC_W-1:0] & SC_LOAD_D)) begin
                        d.ld_d = 1'b1;
                        if (wdata[SC_BURST_BIT]) begin
                            d.go    = 1'b1;
                            d.state = ST_RUNNING;
                        end
                    end
                    if (|(wdata[SC_W-1:0] & SC_LOAD_C)) d.ld_c = 1'b1;
                end
                default: ;
            endcase
        end
        d.pend = d.pend | {{(32-IRQ_W){1'b0}}, irq_set};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_RESET;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        masked_w = q.pend & q.mask;
        stat_w   = '0;
        stat_w[2:0] = q.state;
        stat_w[STAT_EOL_BIT] = eng_eol;
        stat_w[STAT_SRC_LSB +: SRC_W] = eng_src;
        case (idx)
            IX_DATA:   rd_word = q.data;
            IX_SAVED:  rd_word = q.saved;
            IX_SBUF:   rd_word = q.sbuf;
            IX_GROUP:  rd_word = q.grp;
            IX_GDOWN:  rd_word = q.gdown;
            IX_CMD:    rd_word = q.cmd;
            IX_CFG:    rd_word = q.cfg;
            IX_STAT:   rd_word = stat_w;
            IX_MASK:   rd_word = q.mask;
            IX_RAW:    rd_word = q.pend;
            IX_MASKED: rd_word = masked_w;
            IX_STREAM: rd_word = {{(32-SC_W){1'b0}}, q.stream};
            default:   rd_word = '0;
        endcase
    end

    assign irq     = |masked_w;
    assign ld_data = q.ld_d;
    assign ld_ctx  = q.ld_c;
    assign start   = q.go;
    assign cont    = q.cont;
    assign bad_cmd = q.bad;

    assert_state_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(q.state) == 1);

    assert_cfg_off_resets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == IX_CFG && !wdata[0]) |=> (q.state == ST_RESET));

    assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == IX_ACK && irq_set == '0) |=> ((q.pend & $past(wdata)) == '0));

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_set) |=> ((q.pend[IRQ_W-1:0] & $past(irq_set)) == $past(irq_set)));

    assert_start_running_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (q.state == ST_RUNNING && ld_data));

    assert_bad_with_cont_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bad_cmd |-> cont);

endmodule

// File: rtl/dmacsr_top.sv
module dmacsr_top
    import dmacsr_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int SRC_W  = 8,
    parameter int IRQ_W  = 4,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int ADDR_W = WIN_SHIFT + CH_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_req,
    input  logic                    bus_wr,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [2:0]              bus_size,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    output logic                    bus_rvalid,
    output logic                    bus_err,
    input  logic [NUM_CH-1:0]       eng_eol,
    input  logic [NUM_CH*SRC_W-1:0] eng_src,
    input  logic [NUM_CH*IRQ_W-1:0] eng_irq_set,
    output logic [NUM_CH-1:0]       ld_data,
    output logic [NUM_CH-1:0]       ld_ctx,
    output logic [NUM_CH-1:0]       start_ch,
    output logic [NUM_CH-1:0]       cont_req,
    output logic [NUM_CH-1:0]       cmd_bad,
    output logic [NUM_CH-1:0]       irq
);
    logic             wr_hit, rd_req, bad_size, ch_ok;
    logic [CH_W-1:0]  ch;
    logic [IDX_W-1:0] idx;
    logic [31:0]      rd_words [NUM_CH];
    bus_q_t           q, d;

    dmacsr_decode #(.NUM_CH(NUM_CH), .CH_W(CH_W), .ADDR_W(ADDR_W)) u_dec (
        .req      (bus_req),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .size     (bus_size),
        .wr_hit   (wr_hit),
        .rd_req   (rd_req),
        .bad_size (bad_size),
        .ch_ok    (ch_ok),
        .ch       (ch),
        .idx      (idx)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        dmacsr_chan #(.SRC_W(SRC_W), .IRQ_W(IRQ_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_hit && (ch == CH_W'(g))),
            .idx     (idx),
            .wdata   (bus_wdata),
            .eng_eol (eng_eol[g]),
            .eng_src (eng_src[g*SRC_W +: SRC_W]),
            .irq_set (eng_irq_set[g*IRQ_W +: IRQ_W]),
            .rd_word (rd_words[g]),
            .irq     (irq[g]),
            .ld_data (ld_data[g]),
            .ld_ctx  (ld_ctx[g]),
            .start   (start_ch[g]),
            .cont    (cont_req[g]),
            .bad_cmd (cmd_bad[g])
        );
    end

    always_comb begin
        d        = q;
        d.rvalid = rd_req;
        d.err    = bad_size;
        if (rd_req) d.rdata = ch_ok ? rd_words[ch] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bus_rvalid = q.rvalid;
    assign bus_rdata  = q.rdata;
    assign bus_err    = q.err;

    assert_err_no_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> !bus_rvalid);

    assert_err_follows_size_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_size != 3'd4) |=> bus_err);

endmodule

// File: tb/dmacsr_top_tb_top.sv
module dmacsr_top_tb_top;
    localparam int NC = 2;
    localparam int SW = 8;
    localparam int IW = 4;
    localparam int AW = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          bus_req = 0, bus_wr = 0;
    logic [AW-1:0] bus_addr = '0;
    logic [2:0]    bus_size = 3'd4;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          bus_rvalid, bus_err;
    logic [NC-1:0]    eng_eol = '0;
    logic [NC*SW-1:0] eng_src = '0;
    logic [NC*IW-1:0] eng_irq_set = '0;
    logic [NC-1:0] ld_data, ld_ctx, start_ch, cont_req, cmd_bad, irq;

    dmacsr_top #(.NUM_CH(NC), .SRC_W(SW), .IRQ_W(IW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .bus_err(bus_err),
        .eng_eol(eng_eol), .eng_src(eng_src), .eng_irq_set(eng_irq_set),
        .ld_data(ld_data), .ld_ctx(ld_ctx), .start_ch(start_ch),
        .cont_req(cont_req), .cmd_bad(cmd_bad), .irq(irq)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    logic [31:0]   m_reg [NC][64];
    int            m_st  [NC];
    logic          m_rv, m_er;
    logic [31:0]   m_rd;
    logic [NC-1:0] m_ld, m_lc, m_go, m_ct, m_bd;

    function automatic logic [31:0] m_read(int c, int ix);
        logic [31:0] r;
        case (ix)
            'h22: begin
                r = 32'(m_st[c]);
                if (eng_eol[c]) r = r | 32'h20;
                r = r | (32'(eng_src[c*SW +: SW]) << 8);
            end
            'h24: r = 0;
            'h26: r = m_reg[c]['h25] & m_reg[c]['h23];
            default: r = m_reg[c][ix];
        endcase
        return r;
    endfunction

    task automatic m_write(int c, int ix, logic [31:0] v);
        case (ix)
            'h00, 'h16, 'h17, 'h18, 'h1F, 'h23: m_reg[c][ix] = v;
            'h20: begin
                m_reg[c][ix] = v;
                m_ct[c] = 1'b1;
                m_bd[c] = (v > 1);
            end
            'h21: begin
                m_reg[c][ix] = v;
                if (v[1]) m_st[c] = 2;
                if (!v[0]) m_st[c] = 1;
            end
            'h24: m_reg[c]['h25] = m_reg[c]['h25] & ~v;
            'h27: begin
                m_reg[c][ix] = v & 32'h3FF;
                if ((v & 32'h140) != 0) begin
                    m_ld[c] = 1'b1;
                    if ((v & 32'h20) != 0) begin
                        m_go[c] = 1'b1;
                        m_st[c] = 4;
                    end
                end
                if ((v & 32'h200) != 0) m_lc[c] = 1'b1;
            end
            default: ;
        endcase
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NC; c++) begin
                for (int i = 0; i < 64; i++) m_reg[c][i] = '0;
                m_st[c] = 1;
            end
            m_rv = 0; m_er = 0; m_rd = '0;
            m_ld = '0; m_lc = '0; m_go = '0; m_ct = '0; m_bd = '0;
        end else begin
            m_rv = 0; m_er = 0;
            m_ld = '0; m_lc = '0; m_go = '0; m_ct = '0; m_bd = '0;
            if (bus_req) begin
                if (bus_size != 3'd4) m_er = 1;
                else begin
                    int c;
                    int ix;
                    c  = int'(bus_addr >> 13);
                    ix = int'(bus_addr[7:2]);
                    if (!bus_wr) begin
                        m_rv = 1;
                        m_rd = (c < NC) ? m_read(c, ix) : '0;
                    end else if (c < NC) begin
                        m_write(c, ix, bus_wdata);
                    end
                end
            end
            for (int c = 0; c < NC; c++)
                m_reg[c]['h25] = m_reg[c]['h25] | 32'(eng_irq_set[c*IW +: IW]);
        end
        #2;
        if (rst_n) begin
            logic [NC-1:0] m_irq;
            for (int c = 0; c < NC; c++) m_irq[c] = |(m_reg[c]['h25] & m_reg[c]['h23]);
            check("R1 rvalid", 32'(bus_rvalid), 32'(m_rv));
            if (m_rv) check("R1 rdata", bus_rdata, m_rd);
            check("R10 err", 32'(bus_err), 32'(m_er));
            check("R8 ld_data", 32'(ld_data), 32'(m_ld));
            check("R8 ld_ctx", 32'(ld_ctx), 32'(m_lc));
            check("R8 start", 32'(start_ch), 32'(m_go));
            check("R9 cont", 32'(cont_req), 32'(m_ct));
            check("R9 bad", 32'(cmd_bad), 32'(m_bd));
            check("R6 irq", 32'(irq), 32'(m_irq));
        end
    end

    task automatic wr(logic [AW-1:0] a, logic [31:0] v);
        @(negedge clk);
        bus_req = 1; bus_wr = 1; bus_addr = a; bus_wdata = v; bus_size = 3'd4;
        @(negedge clk);
        bus_req = 0; bus_wr = 0;
    endtask

    task automatic rd(logic [AW-1:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        bus_req = 1; bus_wr = 0; bus_addr = a; bus_size = 3'd4;
        @(negedge clk);
        bus_req = 0;
        check(tag, 32'(bus_rvalid), 32'd1);
        check(tag, bus_rdata, exp);
    endtask

    task automatic pulse_set(int c, logic [IW-1:0] v);
        @(negedge clk);
        eng_irq_set[c*IW +: IW] = v;
        @(negedge clk);
        eng_irq_set = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R2 reset values
        rd(14'h0088, 32'h1, "R2 status ch0");
        rd(14'h2088, 32'h1, "R2 status ch1");
        rd(14'h0094, 32'h0, "R2 pending");
        rd(14'h2084, 32'h0, "R2 config");

        // R1 / R11 pointers and isolation
        wr(14'h0000, 32'hDEADBEEF);
        wr(14'h2058, 32'h12345678);
        wr(14'h007C, 32'hCAFE0001);
        rd(14'h0000, 32'hDEADBEEF, "R11 data ch0");
        rd(14'h2000, 32'h0, "R11 ch1 untouched");
        rd(14'h2058, 32'h12345678, "R11 saved ch1");
        rd(14'h007C, 32'hCAFE0001, "R1 group-down");
        wr(14'h0004, 32'hFFFF);
        rd(14'h0004, 32'h0, "R1 unmapped");

        // R3 config and state
        wr(14'h0084, 32'h3);
        rd(14'h0088, 32'h2, "R3 stop");
        wr(14'h0084, 32'h2);
        rd(14'h0088, 32'h1, "R3 disable wins");
        wr(14'h0084, 32'h1);
        rd(14'h0088, 32'h1, "R3 unchanged");
        rd(14'h0084, 32'h1, "R11 config readback");

        // R8 stream command
        wr(14'h009C, 32'hFFFFF160);
        check("R8 ld pulse", 32'(ld_data), 32'h1);
        check("R8 start pulse", 32'(start_ch), 32'h1);
        check("R8 no ctx", 32'(ld_ctx), 32'h0);
        rd(14'h0088, 32'h4, "R8 running");
        rd(14'h009C, 32'h160, "R8 low bits");
        wr(14'h009C, 32'h200);
        check("R8 ctx pulse", 32'(ld_ctx), 32'h1);
        check("R8 no load", 32'(ld_data), 32'h0);

        // R4 live status
        eng_eol[0] = 1'b1;
        eng_src[0 +: SW] = 8'hA5;
        rd(14'h0088, 32'h0000A524, "R4 status");
        eng_eol = '0;
        eng_src = '0;

        // R6 / R7 / R5 interrupts
        pulse_set(0, 4'b0101);
        check("R7 no irq unmasked", 32'(irq), 32'h0);
        wr(14'h008C, 32'h4);
        check("R6 irq", 32'(irq), 32'h1);
        rd(14'h0098, 32'h4, "R6 masked");
        rd(14'h0094, 32'h5, "R7 pending");
        wr(14'h0090, 32'h4);
        check("R5 irq cleared", 32'(irq), 32'h0);
        rd(14'h0094, 32'h1, "R5 pending after ack");
        rd(14'h0090, 32'h0, "R5 ack reads zero");
        @(negedge clk);
        bus_req = 1; bus_wr = 1; bus_addr = 14'h0090; bus_wdata = 32'h1; bus_size = 3'd4;
        eng_irq_set[0 +: IW] = 4'b0001;
        @(negedge clk);
        bus_req = 0; bus_wr = 0; eng_irq_set = '0;
        rd(14'h0094, 32'h1, "R7 set wins");
        wr(14'h0090, 32'h1);
        rd(14'h0094, 32'h0, "R5 clear");
        pulse_set(1, 4'b0010);
        wr(14'h208C, 32'h2);
        check("R6 ch1 irq", 32'(irq), 32'h2);

        // R9 command
        wr(14'h0080, 32'h1);
        check("R9 cont", 32'(cont_req), 32'h1);
        check("R9 good", 32'(cmd_bad), 32'h0);
        wr(14'h0080, 32'h3);
        check("R9 bad", 32'(cmd_bad), 32'h1);

        // R10 bad size
        @(negedge clk);
        bus_req = 1; bus_wr = 1; bus_addr = 14'h0000; bus_wdata = 32'h0; bus_size = 3'd2;
        @(negedge clk);
        bus_req = 0; bus_wr = 0; bus_size = 3'd4;
        check("R10 err", 32'(bus_err), 32'h1);
        rd(14'h0000, 32'hDEADBEEF, "R10 unchanged");

        repeat (3) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule